// File: doc/BRIEF.md
# Running Multi-Channel Cross-Correlator

This block tracks the transit delay between one reference sensor and three other sensors. Four signed 12-bit samples arrive together over a valid/ready stream. Every accepted sample set updates three full correlation functions: channel 0 against channel 1, against channel 2 and against channel 3. Each function covers LAGS delay bins of one sample period each. After that update the block reports, for each pair, the delay bin that holds the largest correlation and the value in that bin. A fresh result therefore appears after every sample, not once per block of samples.

Each pair keeps one accumulator per lag. The accumulator holds a sliding sum over the last WIN reference samples. When a sample set is accepted, the sweep adds the newest product to each lag and removes the product that has just left the window. The sweep handles one lag per clock and works on all three pairs in parallel. While it runs, s_ready stays low. If a source presents a sample while s_ready is low, the sample is not lost: it waits on the bus until it is accepted. The same event also sets a sticky overrun flag, which shows that the sample rate is too high for the configured lag range.

Top module: `xcorr_peak_tracker`

## Requirements
- R1: A sample set is taken on a rising clock edge where s_valid and s_ready are both high. s_ready then stays low for the next LAGS cycles while the sweep runs. A source whose s_valid is refused keeps the same set on the bus, and that set is taken once s_ready returns.
- R2: done_o goes high for exactly one cycle, LAGS clock edges after the edge that took the sample set. s_ready is high again in that same cycle, so a waiting sample can be taken at once, one set per LAGS+1 cycles.
- R3: Samples are signed two's complement. For pair p (channel 0 against channel p+1) and lag k, the correlation after newest sample n is C(k) = sum over j = 0 to WIN-1 of x0[n-j] * xq[n-j-k], where q = p+1. Any sample taken before the first accepted one counts as zero.
- R4: The reported lag of each pair is the k in 0 to LAGS-1 with the largest C(k). When several lags share that maximum, the smallest k is reported.
- R5: The reported value of each pair is C(k) at the reported lag, in ACC_W-bit two's complement.
- R6: The reported lag and value of every pair change only in the cycle in which done_o is high. At all other times they are held.
- R7: overrun_o is set in the cycle after any edge where s_valid is high and s_ready is low. It then stays set until reset.
- R8: During and directly after reset: s_ready = 1, done_o = 0, overrun_o = 0, and every reported lag and value is 0.
- R9: A product leaves every accumulator once its reference sample is more than WIN-1 samples old. The window length therefore stays fixed over an unbounded run.
- R10: Pair p occupies bits [p*LAG_W +: LAG_W] of pk_lag_o and bits [p*ACC_W +: ACC_W] of pk_val_o, for p = 0, 1, 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Sample set present |
| s_ready | output | 1 | Block can take a sample set |
| s_ch0 | input | SMP_W | Reference channel sample, signed |
| s_ch1 | input | SMP_W | Channel 1 sample, signed |
| s_ch2 | input | SMP_W | Channel 2 sample, signed |
| s_ch3 | input | SMP_W | Channel 3 sample, signed |
| done_o | output | 1 | One-cycle pulse: new results valid |
| pk_lag_o | output | 3*LAG_W | Peak lag per pair |
| pk_val_o | output | 3*ACC_W | Correlation at peak lag per pair, signed |
| overrun_o | output | 1 | Sticky: a sample set was offered while busy |

## Verification
s_ready falls in the cycle after the accepting edge. It rises again, together with the single done_o cycle, LAGS edges after that accepting edge. The new peak fields appear in that same done cycle. overrun_o follows one edge after a refused s_valid. The bench counts these latencies with a busy counter in its reference model. The model recomputes every correlation from the full sample history. On the falling edge of every clock, the bench compares s_ready, done_o, overrun_o and all six peak fields against the model's prediction for that exact cycle. Any early or late result is therefore caught as a mismatch.

// File: rtl/xcp_pkg.sv
package xcp_pkg;
  // Sequencer phases: waiting for a sample set, or sweeping the lags.
  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_SWEEP = 1'b1
  } seq_state_e;
endpackage

// File: rtl/xcp_hist_ring.sv
// Circular history of one channel, with two read ports addressed by age.
// Age 0 is the newest sample. Ages not yet written read as zero.
module xcp_hist_ring #(
  parameter int SMP_W = 12,
  parameter int DEPTH = 544,
  parameter int AW    = $clog2(DEPTH),
  parameter int FW    = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic signed [SMP_W-1:0] wr_data,
  input  logic [AW-1:0]           head,
  input  logic [FW-1:0]           fill,
  input  logic [AW-1:0]           age_a,
  input  logic [AW-1:0]           age_b,
  output logic signed [SMP_W-1:0] rd_a,
  output logic signed [SMP_W-1:0] rd_b
);
  logic signed [SMP_W-1:0] mem [DEPTH];
  logic [AW-1:0] addr_a, addr_b;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // Step back from head by age, wrapping at DEPTH.
  always_comb begin
    addr_a = (head >= age_a) ? head - age_a : head + AW'(DEPTH) - age_a;
    addr_b = (head >= age_b) ? head - age_b : head + AW'(DEPTH) - age_b;
  end

  assign rd_a = (FW'(age_a) < fill) ? mem[addr_a] : '0;
  assign rd_b = (FW'(age_b) < fill) ? mem[addr_b] : '0;
endmodule

// File: rtl/xcp_seq.sv
// Accepts sample sets, owns the write pointer and fill level,
// and steps the lag counter through one sweep per accepted set.
module xcp_seq
  import xcp_pkg::*;
#(
  parameter int LAGS  = 512,
  parameter int DEPTH = 544,
  parameter int LAG_W = $clog2(LAGS),
  parameter int AW    = $clog2(DEPTH),
  parameter int FW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  output logic             s_ready,
  output logic             take,
  output logic [AW-1:0]    wr_addr,
  output logic [AW-1:0]    head,
  output logic [FW-1:0]    fill,
  output logic [LAG_W-1:0] lag,
  output logic             step,
  output logic             clr,
  output logic             done,
  output logic             overrun
);
  seq_state_e state;
  logic       last_lag;

  assign s_ready  = (state == SEQ_IDLE);
  assign take     = s_valid && s_ready;
  assign wr_addr  = (head == AW'(DEPTH - 1)) ? '0 : head + AW'(1);
  assign step     = (state == SEQ_SWEEP);
  assign clr      = (fill == FW'(1));
  assign last_lag = (lag == LAG_W'(LAGS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SEQ_IDLE;
      head    <= AW'(DEPTH - 1);
      fill    <= '0;
      lag     <= '0;
      done    <= 1'b0;
      overrun <= 1'b0;
    end else begin
      done <= 1'b0;
      if (s_valid && !s_ready) overrun <= 1'b1;
      case (state)
        SEQ_IDLE: begin
          if (take) begin
            head  <= wr_addr;
            fill  <= (fill == FW'(DEPTH)) ? fill : fill + FW'(1);
            lag   <= '0;
            state <= SEQ_SWEEP;
          end
        end
        SEQ_SWEEP: begin
          if (last_lag) begin
            lag   <= '0;
            done  <= 1'b1;
            state <= SEQ_IDLE;
          end else begin
            lag <= lag + LAG_W'(1);
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xcp_lag_engine.sv
// One channel pair: per-lag sliding-window accumulators plus a running
// first-maximum search. The peak is latched at the last lag of a sweep.
module xcp_lag_engine #(
  parameter int SMP_W = 12,
  parameter int LAGS  = 512,
  parameter int LAG_W = $clog2(LAGS),
  parameter int ACC_W = 30
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step,
  input  logic [LAG_W-1:0]        lag,
  input  logic                    clr,
  input  logic signed [SMP_W-1:0] ref_new,
  input  logic signed [SMP_W-1:0] ref_old,
  input  logic signed [SMP_W-1:0] oth_new,
  input  logic signed [SMP_W-1:0] oth_old,
  output logic [LAG_W-1:0]        pk_lag,
  output logic signed [ACC_W-1:0] pk_val
);
  localparam int PROD_W = 2 * SMP_W;

  logic signed [ACC_W-1:0]  acc_mem [LAGS];
  logic signed [PROD_W-1:0] p_new, p_old;
  logic signed [ACC_W-1:0]  acc_cur, acc_nxt;
  logic signed [ACC_W-1:0]  run_max;
  logic [LAG_W-1:0]         run_lag;
  logic                     first_lag, last_lag, best_hit;

  assign p_new     = ref_new * oth_new;
  assign p_old     = ref_old * oth_old;
  assign first_lag = (lag == '0);
  assign last_lag  = (lag == LAG_W'(LAGS - 1));

  always_comb begin
    acc_cur  = clr ? '0 : acc_mem[lag];
    acc_nxt  = acc_cur + ACC_W'(p_new) - ACC_W'(p_old);
    // A strict compare keeps the earliest lag on ties.
    best_hit = first_lag || (acc_nxt > run_max);
  end

  always_ff @(posedge clk) begin
    if (step) acc_mem[lag] <= acc_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_max <= '0;
      run_lag <= '0;
      pk_lag  <= '0;
      pk_val  <= '0;
    end else if (step) begin
      if (best_hit) begin
        run_max <= acc_nxt;
        run_lag <= lag;
      end
      if (last_lag) begin
        pk_val <= best_hit ? acc_nxt : run_max;
        pk_lag <= best_hit ? lag : run_lag;
      end
    end
  end
endmodule

// File: rtl/xcorr_peak_tracker.sv
module xcorr_peak_tracker #(
  parameter int SMP_W = 12,
  parameter int LAGS  = 512,
  parameter int WIN   = 32,
  parameter int NPAIR = 3,
  parameter int LAG_W = $clog2(LAGS),
  parameter int ACC_W = 2 * SMP_W + $clog2(WIN) + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   s_valid,
  output logic                   s_ready,
  input  logic [SMP_W-1:0]       s_ch0,
  input  logic [SMP_W-1:0]       s_ch1,
  input  logic [SMP_W-1:0]       s_ch2,
  input  logic [SMP_W-1:0]       s_ch3,
  output logic                   done_o,
  output logic [NPAIR*LAG_W-1:0] pk_lag_o,
  output logic [NPAIR*ACC_W-1:0] pk_val_o,
  output logic                   overrun_o
);
  localparam int NCH   = NPAIR + 1;
  localparam int DEPTH = LAGS + WIN;
  localparam int AW    = $clog2(DEPTH);
  localparam int FW    = $clog2(DEPTH + 1);

  logic                    take, step, clr;
  logic [AW-1:0]           wr_addr, head;
  logic [FW-1:0]           fill;
  logic [LAG_W-1:0]        lag;
  logic signed [SMP_W-1:0] smp    [NCH];
  logic signed [SMP_W-1:0] rd_new [NCH];
  logic signed [SMP_W-1:0] rd_old [NCH];

  assign smp[0] = $signed(s_ch0);
  assign smp[1] = $signed(s_ch1);
  assign smp[2] = $signed(s_ch2);
  assign smp[3] = $signed(s_ch3);

  xcp_seq #(
    .LAGS(LAGS), .DEPTH(DEPTH), .LAG_W(LAG_W), .AW(AW), .FW(FW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .take(take), .wr_addr(wr_addr), .head(head), .fill(fill),
    .lag(lag), .step(step), .clr(clr), .done(done_o), .overrun(overrun_o)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    // Reference channel reads fixed ages; the others read at the swept lag.
    logic [AW-1:0] age_new, age_old;
    if (c == 0) begin : g_ref
      assign age_new = '0;
      assign age_old = AW'(WIN);
    end else begin : g_oth
      assign age_new = AW'(lag);
      assign age_old = AW'(lag) + AW'(WIN);
    end
    xcp_hist_ring #(
      .SMP_W(SMP_W), .DEPTH(DEPTH), .AW(AW), .FW(FW)
    ) u_ring (
      .clk(clk), .wr_en(take), .wr_addr(wr_addr), .wr_data(smp[c]),
      .head(head), .fill(fill), .age_a(age_new), .age_b(age_old),
      .rd_a(rd_new[c]), .rd_b(rd_old[c])
    );
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic signed [ACC_W-1:0] val;
    xcp_lag_engine #(
      .SMP_W(SMP_W), .LAGS(LAGS), .LAG_W(LAG_W), .ACC_W(ACC_W)
    ) u_eng (
      .clk(clk), .rst_n(rst_n), .step(step), .lag(lag), .clr(clr),
      .ref_new(rd_new[0]), .ref_old(rd_old[0]),
      .oth_new(rd_new[p+1]), .oth_old(rd_old[p+1]),
      .pk_lag(pk_lag_o[p*LAG_W +: LAG_W]), .pk_val(val)
    );
    assign pk_val_o[p*ACC_W +: ACC_W] = val;
  end
endmodule

// File: rtl/xcp_chk.sv
module xcp_chk #(
  parameter int LAGS  = 512,
  parameter int LAG_W = 9,
  parameter int ACC_W = 30,
  parameter int NPAIR = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   s_valid,
  input logic                   s_ready,
  input logic                   done_o,
  input logic [NPAIR*LAG_W-1:0] pk_lag_o,
  input logic [NPAIR*ACC_W-1:0] pk_val_o,
  input logic                   overrun_o
);
  // Edges since the last accept, saturating one past LAGS.
  logic [LAG_W+1:0] since;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since <= '0;
    else if (s_valid && s_ready) since <= (LAG_W+2)'(1);
    else if (since != '0 && since <= (LAG_W+2)'(LAGS)) since <= since + (LAG_W+2)'(1);
  end

  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);
  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R2
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> s_ready);
  // R2
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (since == (LAG_W+2)'(LAGS + 1)));
  // R6
  peak_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(pk_lag_o) && $stable(pk_val_o)));
  // R7
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !s_ready) |=> overrun_o);
  // R7
  overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |=> overrun_o);
endmodule

bind xcorr_peak_tracker xcp_chk #(
  .LAGS(LAGS), .LAG_W(LAG_W), .ACC_W(ACC_W), .NPAIR(NPAIR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .done_o(done_o), .pk_lag_o(pk_lag_o), .pk_val_o(pk_val_o),
  .overrun_o(overrun_o)
);

// File: tb/xcorr_peak_tracker_tb.sv
module xcorr_peak_tracker_tb;
  localparam int SMP_W = 12;
  localparam int LAGS  = 512;
  localparam int WIN   = 32;
  localparam int NPAIR = 3;
  localparam int LAG_W = 9;
  localparam int ACC_W = 30;
  localparam int NS    = 110;
  localparam int PHB   = 92;   // from here on the source does not wait for ready

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                   rst_n, s_valid, s_ready, done_o, overrun_o;
  logic [SMP_W-1:0]       s_ch0, s_ch1, s_ch2, s_ch3;
  logic [NPAIR*LAG_W-1:0] pk_lag_o;
  logic [NPAIR*ACC_W-1:0] pk_val_o;

  xcorr_peak_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_ch0(s_ch0), .s_ch1(s_ch1), .s_ch2(s_ch2), .s_ch3(s_ch3),
    .done_o(done_o), .pk_lag_o(pk_lag_o), .pk_val_o(pk_val_o),
    .overrun_o(overrun_o)
  );

  int     total = 0, bad = 0;
  int     x [4][NS];
  longint e_val [NPAIR], n_val [NPAIR];
  int     e_lag [NPAIR], n_lag [NPAIR];
  int     busy_left = 0;
  bit     e_done = 0, e_ovr = 0;

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R3: direct windowed sum, zero before the first sample.
  function automatic longint corr(int q, int n, int k);
    longint s = 0;
    for (int j = 0; j < WIN; j++) begin
      if (n - j >= 0 && n - j - k >= 0) s += longint'(x[0][n-j]) * longint'(x[q][n-j-k]);
    end
    return s;
  endfunction

  // R4: first lag holding the maximum.
  task automatic peaks(int n);
    for (int p = 0; p < NPAIR; p++) begin
      longint best = 0;
      int     bl = 0;
      for (int k = 0; k < LAGS; k++) begin
        longint c = corr(p + 1, n, k);
        if (k == 0 || c > best) begin best = c; bl = k; end
      end
      n_val[p] = best;
      n_lag[p] = bl;
    end
  endtask

  task automatic compare_all();
    chk("R1 ready", longint'(s_ready), longint'(busy_left == 0));
    chk("R2 done", longint'(done_o), longint'(e_done));
    chk("R7 overrun", longint'(overrun_o), longint'(e_ovr));
    for (int p = 0; p < NPAIR; p++) begin
      // R10: pair fields by position; R6: held between pulses
      chk("R4 R10 lag", longint'(pk_lag_o[p*LAG_W +: LAG_W]), longint'(e_lag[p]));
      chk("R5 R9 value", longint'($signed(pk_val_o[p*ACC_W +: ACC_W])), e_val[p]);
    end
  endtask

  initial begin
    // Stimulus history: zeros (all lags tie), delayed copies,
    // full-scale negative block (ties again), then mixed signals.
    for (int n = 0; n < NS; n++) begin
      if (n < 3) begin
        for (int c = 0; c < 4; c++) x[c][n] = 0;
      end else if (n < 60) begin
        x[0][n] = int'($urandom_range(4095)) - 2048;
        x[1][n] = (n >= 6)  ? x[0][n-3]  : 0;
        x[2][n] = (n >= 20) ? x[0][n-17] : 0;
        x[3][n] = (n >= 44) ? -x[0][n-41] : 0;
      end else if (n < 75) begin
        for (int c = 0; c < 4; c++) x[c][n] = -2048;
      end else begin
        x[0][n] = int'($urandom_range(4095)) - 2048;
        x[1][n] = x[0][n-7];
        x[2][n] = int'($urandom_range(4095)) - 2048;
        x[3][n] = 2047;
      end
    end
    for (int p = 0; p < NPAIR; p++) begin e_lag[p] = 0; e_val[p] = 0; end
  end

  initial begin
    int idx = 0;
    int gap = 0;
    rst_n = 1'b0; s_valid = 1'b0;
    s_ch0 = '0; s_ch1 = '0; s_ch2 = '0; s_ch3 = '0;
    repeat (3) @(negedge clk);
    // R8: reset state while reset is held
    chk("R8 ready", longint'(s_ready), 1);
    chk("R8 done", longint'(done_o), 0);
    chk("R8 overrun", longint'(overrun_o), 0);
    chk("R8 lag", longint'(pk_lag_o), 0);
    chk("R8 value", longint'(pk_val_o != '0), 0);
    rst_n = 1'b1;
    while (idx < NS || busy_left > 0) begin
      int b0;
      @(negedge clk);
      compare_all();
      // drive for the coming edge
      if (idx >= NS) s_valid = 1'b0;
      else if (idx >= PHB) s_valid = 1'b1;
      else s_valid = (busy_left == 0 && gap == 0);
      if (busy_left == 0 && gap > 0) gap--;
      if (idx < NS) begin
        s_ch0 = 12'(x[0][idx]); s_ch1 = 12'(x[1][idx]);
        s_ch2 = 12'(x[2][idx]); s_ch3 = 12'(x[3][idx]);
      end
      // next-cycle expectations
      b0 = busy_left;
      e_done = 0;
      if (s_valid && b0 != 0) e_ovr = 1;
      if (s_valid && b0 == 0) begin
        peaks(idx);
        idx++;
        busy_left = LAGS;
        gap = idx % 3;
      end else if (b0 > 0) begin
        busy_left--;
        if (busy_left == 0) begin
          e_done = 1;
          for (int p = 0; p < NPAIR; p++) begin e_lag[p] = n_lag[p]; e_val[p] = n_val[p]; end
        end
      end
    end
    repeat (3) begin
      @(negedge clk);
      compare_all();
      e_done = 0;
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 190000);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule